// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array Model

This block is a cycle-based, synthesizable model of a dynamic memory device. The array is square and every location holds one 4-bit word. Row and column addresses do not have separate pins. They share one narrow address bus and are captured one after the other under two separate strobes. A single width parameter sets both the row count and the column count. Adding one address line therefore doubles each dimension and gives four times the capacity. The full-size part uses an 11-bit bus and a 2048 by 2048 grid. The default here is 3 bits, which keeps simulation small.

When a row is opened, the whole row is copied into a row buffer. Every column read and write then works on that buffer. When the row strobe is released, the buffer is written back to the array as a whole row. This read-out and write-back is the refresh mechanism. There are two ways to start a refresh:
- Open a row and close it again with no column access.
- Pulse a separate refresh request. This refreshes the row named by an internal counter. The counter then advances and wraps after the last row.

Top module: `mux_dram_model`

## Requirements
- R1: After reset every location reads as zero and `dout` is zero.
- R2: The array has 2^ADDR_W rows and 2^ADDR_W columns of 4-bit words, addressed through the single `addr` bus.
  - With the block idle, `row_sel` high at a clock edge latches `addr` as the row.
  - While that row stays open, the first edge with `col_sel` high latches `addr` as the column.
- R3: Write and read:
  - If `wr_en` and `col_sel` stay high for the edge after the column is latched, `din` is stored at the addressed word.
  - With `out_en` high, `dout` shows the addressed word from the column-latch edge onward.
- R4: Opening a row loads the entire row into a row buffer, and closing it (`row_sel` low) writes the entire buffer back.
  - Columns that were not written keep their contents.
  - Several column accesses, each a new rise of `col_sel`, may occur inside one row.
- R5: A `ref_req` sampled while idle refreshes the row named by an internal counter. It takes two cycles, then the counter advances by one and wraps after the last row. Stored data is unchanged.
- R6: Opening and closing a row with no column access refreshes that row and leaves its data unchanged.
- R7: `dout` is all zeros whenever `out_en` is low or no column access is active.
- R8: `col_sel` while no row is open is ignored. It causes no write and no output.
- R9: If `row_sel` and `ref_req` are both high while idle, the row access wins and proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| addr | input | ADDR_W | shared row/column address bus |
| row_sel | input | 1 | row strobe, active high |
| col_sel | input | 1 | column strobe, active high |
| wr_en | input | 1 | write enable for the active column |
| out_en | input | 1 | output enable for `dout` |
| ref_req | input | 1 | counter-addressed refresh request |
| din | input | 4 | write data |
| dout | output | 4 | read data, zero when not driven |

## Verification
The bench checks the following corner cases:
- **Whole-row write-back.** It writes one column and then reads its neighbours. A design that wrote back only the touched column, or wrote back a stale buffer, would lose or scramble those neighbours.
- **Refresh between accesses.** It places both kinds of refresh between write and read. A refresh that reloaded the wrong row or wrote garbage would corrupt the stored patterns.
- **Stray column strobe.** It drives `col_sel` with `wr_en` while no row is open. A design that did not ignore this would overwrite a location or drive `dout`.
- **Output enable low.** It holds `out_en` low during an active column. A design that leaked data here would show a non-zero `dout`.

A seeded random mix of operations is compared against a shadow array kept in the bench.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
  localparam int WORD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_REF  = 2'd2
  } mxd_state_e;

  // number of rows (and columns) for a given address width
  function automatic int unsigned grid_dim(input int unsigned aw);
    return 32'd1 << aw;
  endfunction

  // bit offset of a column word inside a packed row
  function automatic int unsigned col_lsb(input int unsigned col, input int unsigned ww);
    return col * ww;
  endfunction
endpackage

// File: rtl/mxd_cell_array.sv
module mxd_cell_array
  import mxd_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W_P = WORD_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     rd_idx,
  output logic [grid_dim(ADDR_W)*WORD_W_P-1:0]  rd_row,
  input  logic                                  wb_row_en,
  input  logic                                  wb_ref_en,
  input  logic [ADDR_W-1:0]                     wr_idx,
  input  logic [grid_dim(ADDR_W)*WORD_W_P-1:0]  wr_row
);
  localparam int ROWS  = grid_dim(ADDR_W);
  localparam int ROW_W = ROWS * WORD_W_P;

  logic [ROW_W-1:0] mem_q [ROWS];
  logic             wr_any;

  assign wr_any = wb_row_en | wb_ref_en;
  assign rd_row = mem_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_any) begin
      mem_q[wr_idx] <= wr_row;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_row_en, wb_ref_en})); // R5
endmodule

// File: rtl/mxd_row_buffer.sv
module mxd_row_buffer
  import mxd_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W_P = WORD_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load,
  input  logic [grid_dim(ADDR_W)*WORD_W_P-1:0]  load_row,
  input  logic                                  col_wr,
  input  logic [ADDR_W-1:0]                     col_idx,
  input  logic [WORD_W_P-1:0]                   col_din,
  output logic [grid_dim(ADDR_W)*WORD_W_P-1:0]  row_out,
  output logic [WORD_W_P-1:0]                   col_dout
);
  localparam int ROW_W = grid_dim(ADDR_W) * WORD_W_P;

  logic [ROW_W-1:0] buf_q;

  assign row_out  = buf_q;
  assign col_dout = buf_q[col_lsb(32'(col_idx), WORD_W_P) +: WORD_W_P];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (load) begin
      buf_q <= load_row;
    end else if (col_wr) begin
      buf_q[col_lsb(32'(col_idx), WORD_W_P) +: WORD_W_P] <= col_din;
    end
  end

  AST_LOAD_XOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && col_wr)); // R4
endmodule

// File: rtl/mxd_ctrl.sv
module mxd_ctrl
  import mxd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              row_sel,
  input  logic              col_sel,
  input  logic              wr_en,
  input  logic              ref_req,
  output logic              buf_load,
  output logic [ADDR_W-1:0] rd_idx,
  output logic              wb_row_en,
  output logic              wb_ref_en,
  output logic [ADDR_W-1:0] wb_idx,
  output logic              col_wr,
  output logic [ADDR_W-1:0] col_idx,
  output logic              col_active,
  output logic              ras_only_evt,
  output logic              ref_done_evt
);
  mxd_state_e        st_q, st_d;
  logic [ADDR_W-1:0] row_q, col_q, ref_ctr_q;
  logic              col_act_q, had_col_q;
  logic              col_rise;

  // next-state and event decode
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (row_sel) st_d = ST_ROW; else if (ref_req) st_d = ST_REF;
      ST_ROW:  if (!row_sel) st_d = ST_IDLE;
      ST_REF:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign buf_load     = (st_q == ST_IDLE) && (row_sel || ref_req);
  assign rd_idx       = row_sel ? addr : ref_ctr_q;
  assign wb_row_en    = (st_q == ST_ROW) && !row_sel;
  assign wb_ref_en    = (st_q == ST_REF);
  assign wb_idx       = wb_ref_en ? ref_ctr_q : row_q;
  assign col_rise     = (st_q == ST_ROW) && row_sel && col_sel && !col_act_q;
  assign col_wr       = (st_q == ST_ROW) && row_sel && col_sel && col_act_q && wr_en;
  assign col_idx      = col_q;
  assign col_active   = col_act_q;
  assign ras_only_evt = wb_row_en && !had_col_q;
  assign ref_done_evt = wb_ref_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      ref_ctr_q <= '0;
      col_act_q <= 1'b0;
      had_col_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && row_sel) begin
        row_q     <= addr;
        had_col_q <= 1'b0;
      end
      if (st_q == ST_ROW && row_sel) col_act_q <= col_sel;
      else                           col_act_q <= 1'b0;
      if (col_rise) begin
        col_q     <= addr;
        had_col_q <= 1'b1;
      end
      if (wb_ref_en) ref_ctr_q <= ref_ctr_q + 1'b1;
    end
  end

  AST_COL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_act_q) |-> (col_q == $past(addr))); // R2
  AST_COL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ROW) |=> !col_act_q); // R8
  AST_REF_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done_evt |=> (ref_ctr_q == $past(ref_ctr_q) + 1'b1)); // R5
  AST_ROW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_row_en |=> (st_q == ST_IDLE && !col_act_q)); // R4
  AST_ROW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && row_sel && ref_req) |=> (st_q == ST_ROW)); // R9
endmodule

// File: rtl/mux_dram_model.sv
module mux_dram_model
  import mxd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              row_sel,
  input  logic              col_sel,
  input  logic              wr_en,
  input  logic              out_en,
  input  logic              ref_req,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int ROW_W = grid_dim(ADDR_W) * WORD_W;

  logic              buf_load, wb_row_en, wb_ref_en, col_wr, col_active;
  logic              ras_only_evt, ref_done_evt;
  logic [ADDR_W-1:0] rd_idx, wb_idx, col_idx;
  logic [ROW_W-1:0]  arr_rd_row, buf_row;
  logic [WORD_W-1:0] col_dout;

  mxd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_sel(row_sel), .col_sel(col_sel),
    .wr_en(wr_en), .ref_req(ref_req), .buf_load(buf_load), .rd_idx(rd_idx),
    .wb_row_en(wb_row_en), .wb_ref_en(wb_ref_en), .wb_idx(wb_idx), .col_wr(col_wr),
    .col_idx(col_idx), .col_active(col_active), .ras_only_evt(ras_only_evt),
    .ref_done_evt(ref_done_evt)
  );

  mxd_cell_array #(.ADDR_W(ADDR_W), .WORD_W_P(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_row(arr_rd_row),
    .wb_row_en(wb_row_en), .wb_ref_en(wb_ref_en), .wr_idx(wb_idx), .wr_row(buf_row)
  );

  mxd_row_buffer #(.ADDR_W(ADDR_W), .WORD_W_P(WORD_W)) u_rowbuf (
    .clk(clk), .rst_n(rst_n), .load(buf_load), .load_row(arr_rd_row),
    .col_wr(col_wr), .col_idx(col_idx), .col_din(din), .row_out(buf_row),
    .col_dout(col_dout)
  );

  assign dout = (out_en && col_active) ? col_dout : '0;

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en || !col_active) |-> (dout == '0)); // R7
  AST_RAS_ONLY_NO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ras_only_evt |-> !col_active); // R6
  AST_REF_NOT_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done_evt |-> !col_active); // R5
endmodule

// File: tb/tb_mux_dram_model.sv
module tb_mux_dram_model;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic          row_sel = 0, col_sel = 0, wr_en = 0, out_en = 0, ref_req = 0;
  logic [3:0]    din = '0;
  logic [3:0]    dout;
  int            n_chk = 0, n_fail = 0;
  logic [3:0]    shadow [N][N];

  mux_dram_model #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_sel(row_sel), .col_sel(col_sel),
    .wr_en(wr_en), .out_en(out_en), .ref_req(ref_req), .din(din), .dout(dout)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] pattern(input int r, input int c);
    return 4'((r * 5 + c * 3 + 1) ^ (c << 1));
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input int r, input int c, input logic [3:0] d);
    @(negedge clk); addr = AW'(r); row_sel = 1;
    @(negedge clk); addr = AW'(c); col_sel = 1; wr_en = 1; din = d;
    @(negedge clk);
    @(negedge clk); col_sel = 0; wr_en = 0; row_sel = 0;
    @(negedge clk);
    shadow[r][c] = d;
  endtask

  task automatic do_read(input int r, input int c, output logic [3:0] q);
    @(negedge clk); addr = AW'(r); row_sel = 1;
    @(negedge clk); addr = AW'(c); col_sel = 1; out_en = 1;
    @(negedge clk); q = dout;
    col_sel = 0; out_en = 0; row_sel = 0;
    @(negedge clk);
  endtask

  task automatic ras_only(input int r);
    @(negedge clk); addr = AW'(r); row_sel = 1;
    @(negedge clk); row_sel = 0;
    @(negedge clk);
  endtask

  task automatic counter_refresh();
    @(negedge clk); ref_req = 1;
    @(negedge clk); ref_req = 0;
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] q;
    void'($urandom(32'd4242));
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) shadow[r][c] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    check("R1 dout after reset", dout, 4'h0);
    do_read(5, 6, q); check("R1 location zero after reset", q, 4'h0);

    // R2 R3 distinct patterns at several row/column pairs
    do_write(0, 0, 4'hA); do_write(7, 7, 4'h5); do_write(3, 6, 4'hC); do_write(6, 1, 4'h9);
    do_read(0, 0, q); check("R3 read (0,0)", q, 4'hA);
    do_read(7, 7, q); check("R3 read (7,7)", q, 4'h5);
    do_read(3, 6, q); check("R2 read (3,6)", q, 4'hC);
    do_read(6, 1, q); check("R2 read (6,1)", q, 4'h9);
    do_read(3, 5, q); check("R4 neighbour untouched", q, 4'h0);

    // R4 page mode: two column writes within one row
    @(negedge clk); addr = 3'd2; row_sel = 1;
    @(negedge clk); addr = 3'd1; col_sel = 1; wr_en = 1; din = 4'h3;
    @(negedge clk);
    @(negedge clk); col_sel = 0; wr_en = 0;
    @(negedge clk); addr = 3'd4; col_sel = 1; wr_en = 1; din = 4'hE;
    @(negedge clk);
    @(negedge clk); col_sel = 0; wr_en = 0; row_sel = 0;
    @(negedge clk);
    shadow[2][1] = 4'h3; shadow[2][4] = 4'hE;
    do_read(2, 1, q); check("R4 page write first column", q, 4'h3);
    do_read(2, 4, q); check("R4 page write second column", q, 4'hE);

    // R7 out_en low during active column
    @(negedge clk); addr = 3'd0; row_sel = 1;
    @(negedge clk); addr = 3'd0; col_sel = 1; out_en = 0;
    @(negedge clk); check("R7 dout quiet with out_en low", dout, 4'h0);
    out_en = 1; #1; check("R3 dout with out_en high", dout, 4'hA);
    col_sel = 0; row_sel = 0;
    @(negedge clk); check("R7 dout quiet after row close", dout, 4'h0);
    out_en = 0;

    // R8 column strobe without row
    @(negedge clk); addr = 3'd0; col_sel = 1; wr_en = 1; out_en = 1; din = 4'hF;
    @(negedge clk); check("R8 no output without row", dout, 4'h0);
    @(negedge clk); col_sel = 0; wr_en = 0; out_en = 0;
    @(negedge clk);
    do_read(0, 0, q); check("R8 stray column write ignored", q, 4'hA);

    // R6 and R5 refreshes keep data
    ras_only(3); ras_only(7);
    do_read(3, 6, q); check("R6 row-only refresh keeps data", q, 4'hC);
    for (int i = 0; i < N + 3; i++) counter_refresh();
    do_read(7, 7, q); check("R5 counter refresh keeps (7,7)", q, 4'h5);
    do_read(2, 4, q); check("R5 counter refresh keeps (2,4)", q, 4'hE);

    // R9 row_sel and ref_req together
    @(negedge clk); addr = 3'd5; row_sel = 1; ref_req = 1;
    @(negedge clk); ref_req = 0; addr = 3'd2; col_sel = 1; wr_en = 1; din = 4'h6;
    @(negedge clk);
    @(negedge clk); col_sel = 0; wr_en = 0; row_sel = 0;
    @(negedge clk);
    shadow[5][2] = 4'h6;
    do_read(5, 2, q); check("R9 row access wins over refresh", q, 4'h6);

    // random mix against shadow model
    for (int k = 0; k < 300; k++) begin
      int op = $urandom_range(0, 3);
      int r  = $urandom_range(0, N - 1);
      int c  = $urandom_range(0, N - 1);
      case (op)
        0: do_write(r, c, pattern(r, c) ^ 4'($urandom_range(0, 15)));
        1: begin do_read(r, c, q); check("R3 random read", q, shadow[r][c]); end
        2: ras_only(r);
        default: counter_refresh();
      endcase
    end
    for (int r = 0; r < N; r++) begin
      do_read(r, r, q); check("R4 final sweep", q, shadow[r][r]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule